// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down counters behind an 8-bit register interface with a 2-bit address. Software first writes a control word to address 3. The word names a channel, the order in which the count bytes are transferred, a counting mode, and whether the channel counts in binary or in four-digit BCD. Software then writes the count value through the channel's own address, 0 to 2. Each channel drives one output line: a terminal-count flag, a one-clock rate pulse, or a square wave.

A count can be read while the channel keeps running. A latch command copies the live count into a holding register, and that copy stays put until software has read all of it. The counters step only on clock cycles where `cnt_en` is high, so one system clock can serve a slower timebase.

Top module: `ivt_timer3`

## Requirements
- R1: After reset all three outputs are high, every channel is idle with a count of zero, and the access pattern is low byte then high byte.
- R2: A write to address 3 with bits [5:4] not 00 is a control word for the channel in bits [7:6] (00, 01, 10). A selector of 11 changes no channel.
- R3: Control bits [5:4] set the byte access. 01 means the low byte only and the high byte is zero. 10 means the high byte only and the low byte is zero. 11 means the low byte, then the high byte. Reads of a single-byte pattern always return the same byte.
- R4: In the two-byte pattern the new count takes effect only when the high byte is written, and any control word sends the write and read pointers back to the low byte.
- R5: A write to address 3 with bits [5:4] = 00 latches the count of the channel in bits [7:6]. Reads then return the frozen value while counting goes on. The freeze ends after the last byte of the pattern has been read.
- R6: A latch command for a channel that still holds an unread latched value is ignored.
- R7: Mode 000 (bits [3:1]) drives the output low on the control write. The output rises on the tick at which the count reaches zero, which is N ticks after the load.
- R8: Mode 010 drives the output low for exactly one tick every N ticks. The first low tick starts N ticks after the load.
- R9: Mode 011 produces a square wave of period N, high for ceil(N/2) ticks and low for floor(N/2) ticks.
- R10: Bit 0 = 1 selects BCD counting, where each digit wraps from 0 to 9 with a borrow. A loaded count of zero lasts 65536 ticks in binary and 10000 in BCD.
- R11: Mode codes other than 000, 010 and 011 are stored, but the channel output stays high and the count does not change.
- R12: A count changes only on a cycle with `cnt_en` high, or when a count value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count tick enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (advances the read pointer) |
| addr | input | 2 | 0 to 2: channel count registers; 3: control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed channel (combinational) |
| tmr_out | output | 3 | Per-channel output lines |

## Verification
The hardest case to reach from the ports is a latched value that must stay frozen while the live counter moves on under it, together with a second latch command that arrives during the hold. The bench stops `cnt_en`, loads a known count and then releases an exact number of ticks, so the live value is known. It then latches, lets the counter run again, issues a second latch, and reads the bytes. This separates the frozen, the discarded and the live values arithmetically. The waveform modes are swept over every small count on rotating channels, and the two zero-count lengths are run out in full.

// File: rtl/ivt_timer3.sv
module ivt_timer3 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [2:0] tmr_out
);
  localparam int NCH = 3;

  logic [15:0] cnt [NCH];
  logic [15:0] reload [NCH];
  logic [15:0] hold [NCH];
  logic [7:0]  lo_stage [NCH];
  logic [2:0]  mode [NCH];
  logic [1:0]  acc [NCH];
  logic [NCH-1:0] bcd, wr_hi, rd_hi, latched, run;

  logic [NCH-1:0] sel_ctl, sel_lat, sel_wr, sel_rd, load_now, impl;
  logic [15:0] load_val [NCH];
  logic [15:0] dn [NCH];
  logic [16:0] halfv [NCH];

  function automatic logic [15:0] dec_val(input logic [15:0] v, input logic b);
    logic [15:0] r;
    logic borrow;
    if (!b) return v - 16'd1;
    r = v;
    borrow = 1'b1;
    for (int d = 0; d < 4; d++)
      if (borrow) begin
        if (r[d*4 +: 4] == 4'd0) r[d*4 +: 4] = 4'd9;
        else begin
          r[d*4 +: 4] = r[d*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    return r;
  endfunction

  function automatic logic [16:0] to_bin(input logic [15:0] v, input logic b);
    if (v == 16'd0) return b ? 17'd10000 : 17'd65536;
    if (!b) return {1'b0, v};
    return 17'(v[15:12]) * 17'd1000 + 17'(v[11:8]) * 17'd100 +
           17'(v[7:4]) * 17'd10 + 17'(v[3:0]);
  endfunction

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      sel_ctl[i] = wr_en && addr == 2'd3 && wdata[7:6] == 2'(i) && wdata[5:4] != 2'b00;
      sel_lat[i] = wr_en && addr == 2'd3 && wdata[7:6] == 2'(i) && wdata[5:4] == 2'b00;
      sel_wr[i]  = wr_en && addr == 2'(i);
      sel_rd[i]  = rd_en && addr == 2'(i);
      impl[i]    = mode[i] == 3'd0 || mode[i] == 3'd2 || mode[i] == 3'd3;
      case (acc[i])
        2'b01:   begin load_val[i] = {8'h00, wdata};       load_now[i] = sel_wr[i]; end
        2'b10:   begin load_val[i] = {wdata, 8'h00};       load_now[i] = sel_wr[i]; end
        default: begin load_val[i] = {wdata, lo_stage[i]}; load_now[i] = sel_wr[i] && wr_hi[i]; end
      endcase
      dn[i]    = dec_val(cnt[i], bcd[i]);
      halfv[i] = to_bin(reload[i], bcd[i]) >> 1;
    end
  end

  always_comb begin
    logic [15:0] src;
    rdata = 8'h00;
    src   = 16'h0000;
    for (int i = 0; i < NCH; i++)
      if (addr == 2'(i)) begin
        src = latched[i] ? hold[i] : cnt[i];
        case (acc[i])
          2'b01:   rdata = src[7:0];
          2'b10:   rdata = src[15:8];
          default: rdata = rd_hi[i] ? src[15:8] : src[7:0];
        endcase
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        cnt[i] <= '0; reload[i] <= '0; hold[i] <= '0; lo_stage[i] <= '0;
        mode[i] <= 3'b001; acc[i] <= 2'b11;
      end
      bcd <= '0; wr_hi <= '0; rd_hi <= '0; latched <= '0; run <= '0;
      tmr_out <= '1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (sel_ctl[i]) begin
          mode[i]    <= wdata[3:1];
          bcd[i]     <= wdata[0];
          acc[i]     <= wdata[5:4];
          wr_hi[i]   <= 1'b0;
          rd_hi[i]   <= 1'b0;
          latched[i] <= 1'b0;
          run[i]     <= 1'b0;
          tmr_out[i] <= wdata[3:1] != 3'd0;
        end else begin
          if (sel_rd[i]) begin
            if (acc[i] == 2'b11) rd_hi[i] <= ~rd_hi[i];
            if (acc[i] != 2'b11 || rd_hi[i]) latched[i] <= 1'b0;
          end
          if (sel_lat[i] && !latched[i]) begin
            hold[i]    <= cnt[i];
            latched[i] <= 1'b1;
            rd_hi[i]   <= 1'b0;
          end
          if (sel_wr[i] && acc[i] == 2'b11 && !wr_hi[i]) begin
            lo_stage[i] <= wdata;
            wr_hi[i]    <= 1'b1;
          end
          if (load_now[i]) begin
            reload[i]  <= load_val[i];
            cnt[i]     <= load_val[i];
            run[i]     <= impl[i];
            wr_hi[i]   <= 1'b0;
            tmr_out[i] <= mode[i] != 3'd0;
          end else if (run[i] && cnt_en) begin
            case (mode[i])
              3'd0: begin
                cnt[i] <= dn[i];
                if (cnt[i] == 16'd1) tmr_out[i] <= 1'b1;
              end
              3'd2:
                if (cnt[i] == 16'd1) begin
                  cnt[i] <= reload[i]; tmr_out[i] <= 1'b0;
                end else begin
                  cnt[i] <= dn[i]; tmr_out[i] <= 1'b1;
                end
              3'd3:
                if (cnt[i] == 16'd1) begin
                  cnt[i] <= reload[i]; tmr_out[i] <= 1'b1;
                end else begin
                  cnt[i] <= dn[i]; tmr_out[i] <= to_bin(dn[i], bcd[i]) > halfv[i];
                end
              default: ;
            endcase
          end
        end
      end
    end
  end

  logic [47:0] cnt_flat, hold_flat;
  logic [8:0]  mode_flat;
  assign cnt_flat  = {cnt[2], cnt[1], cnt[0]};
  assign hold_flat = {hold[2], hold[1], hold[0]};
  assign mode_flat = {mode[2], mode[1], mode[0]};
endmodule

// File: rtl/ivt_timer3_chk.sv
module ivt_timer3_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cnt_en,
  input logic        wr_en,
  input logic [2:0]  tmr_out,
  input logic [2:0]  latched,
  input logic [47:0] cnt_flat,
  input logic [47:0] hold_flat,
  input logic [8:0]  mode_flat
);
  AST_RESET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> tmr_out == 3'b111); // R1

  for (genvar i = 0; i < 3; i++) begin : g_ch
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      latched[i] |=> $stable(hold_flat[i*16 +: 16])); // R5
    AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !wr_en) |=> $stable(cnt_flat[i*16 +: 16])); // R12
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_flat[i*3 +: 3] inside {3'd0, 3'd2, 3'd3}) |-> tmr_out[i]); // R11
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_flat[i*3 +: 3] == 3'd2 && !tmr_out[i] && cnt_en && !wr_en &&
       cnt_flat[i*16 +: 16] != 16'd1) |=> tmr_out[i]); // R8
  end
endmodule

bind ivt_timer3 ivt_timer3_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .tmr_out(tmr_out),
  .latched(latched), .cnt_flat(cnt_flat), .hold_flat(hold_flat), .mode_flat(mode_flat)
);

// File: tb/ivt_timer3_bench.sv
module ivt_timer3_bench;
  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [2:0] tmr_out;
  int n_chk = 0, n_bad = 0;

  ivt_timer3 u_ivt_timer3 (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .tmr_out(tmr_out));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd16(input logic [1:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic cu(input int ch, input logic lvl, output int n);
    n = 0;
    while (tmr_out[ch] != lvl && n < 70000) begin @(negedge clk); n++; end
  endtask

  task automatic ticks(input int n);
    @(negedge clk); cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    #950000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0] b;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs", tmr_out, 3'b111);
    for (int c = 0; c < 3; c++) begin rd16(2'(c), v); chk("R1 count", v, 0); end

    wr(3, 8'hF0);
    chk("R2 selector 11 ignored", tmr_out, 3'b111);

    for (int n = 1; n <= 9; n++) begin
      int ch = n % 3;
      wr(3, {2'(ch), 2'b11, 3'd0, 1'b0});
      chk("R7 low on control", tmr_out[ch], 0);
      wr(2'(ch), 8'(n)); wr(2'(ch), 8'h00);
      cu(ch, 1'b1, t); chk("R7 terminal ticks", t, n);
    end

    for (int n = 2; n <= 12; n++) begin
      int ch = n % 3;
      wr(3, {2'(ch), 2'b11, 3'd2, 1'b0});
      wr(2'(ch), 8'(n)); wr(2'(ch), 8'h00);
      cu(ch, 1'b0, t); chk("R8 first pulse", t, n);
      cu(ch, 1'b1, t); chk("R8 low width", t, 1);
      cu(ch, 1'b0, t); chk("R8 high width", t, n - 1);
    end

    for (int n = 2; n <= 13; n++) begin
      int ch = (n + 1) % 3;
      wr(3, {2'(ch), 2'b11, 3'd3, 1'b0});
      wr(2'(ch), 8'(n)); wr(2'(ch), 8'h00);
      cu(ch, 1'b0, t); chk("R9 first high", t, (n + 1) / 2);
      cu(ch, 1'b1, t); chk("R9 low half", t, n / 2);
      cu(ch, 1'b0, t); chk("R9 high half", t, (n + 1) / 2);
    end

    wr(3, 8'h77); wr(1, 8'h15); wr(1, 8'h00);
    cu(1, 1'b0, t);
    cu(1, 1'b1, t); chk("R10 R9 bcd low", t, 7);
    cu(1, 1'b0, t); chk("R10 R9 bcd high", t, 8);

    wr(3, 8'h31); wr(0, 8'h12); wr(0, 8'h00);
    cu(0, 1'b1, t); chk("R10 bcd 12", t, 12);
    wr(3, 8'h31); wr(0, 8'h00); wr(0, 8'h00);
    cu(0, 1'b1, t); chk("R10 bcd zero", t, 10000);
    wr(3, 8'h30); wr(0, 8'h00); wr(0, 8'h00);
    cu(0, 1'b1, t); chk("R10 binary zero", t, 65536);
    cnt_en = 1'b0;
    wr(3, 8'h31); wr(0, 8'h00); wr(0, 8'h01);
    ticks(1);
    rd16(0, v); chk("R10 bcd borrow", v, 16'h0099);

    cnt_en = 1'b1;
    wr(3, 8'h30); wr(0, 8'h55);
    wr(3, 8'h30); wr(0, 8'h03); wr(0, 8'h00);
    cu(0, 1'b1, t); chk("R4 pointer reset", t, 3);
    wr(3, 8'h30); wr(0, 8'h05);
    repeat (10) @(negedge clk);
    chk("R4 waits for high byte", tmr_out[0], 0);
    wr(0, 8'h00);
    cu(0, 1'b1, t); chk("R4 starts after high", t, 5);

    cnt_en = 1'b0;
    wr(3, 8'h74); wr(1, 8'hE8); wr(1, 8'h03);
    ticks(37);
    wr(3, 8'h40);
    ticks(20);
    rd16(1, v); chk("R5 R12 latched value", v, 963);
    rd16(1, v); chk("R5 released live", v, 943);
    wr(3, 8'h40);
    ticks(5);
    wr(3, 8'h40);
    rd16(1, v); chk("R6 second latch ignored", v, 943);
    rd16(1, v); chk("R12 live after pause", v, 938);

    wr(3, 8'h94); wr(2, 8'h20);
    rd(2, b); chk("R3 low only", b, 8'h20);
    rd(2, b); chk("R3 low only repeat", b, 8'h20);
    wr(3, 8'hA4); wr(2, 8'h01);
    rd(2, b); chk("R3 high only", b, 8'h01);
    wr(3, 8'h80);
    ticks(3);
    rd(2, b); chk("R3 R5 latched high", b, 8'h01);
    rd(2, b); chk("R3 R5 single read release", b, 8'h00);

    cnt_en = 1'b1;
    wr(3, 8'hB2); wr(2, 8'h10); wr(2, 8'h00);
    repeat (30) @(negedge clk);
    chk("R11 mode 1 output", tmr_out[2], 1);
    rd16(2, v); chk("R11 mode 1 idle count", v, 16);
    wr(3, 8'hBA); wr(2, 8'h04); wr(2, 8'h00);
    repeat (10) @(negedge clk);
    chk("R11 mode 5 output", tmr_out[2], 1);
    rd16(2, v); chk("R11 mode 5 idle count", v, 4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule